// File: doc/BRIEF.md
# Chip Reset Sequencer

This block turns four reset sources into a single synchronous, active-high chip reset. The sources are a power-good level, a low-supply flag from a comparator, an active-low external reset pin, and a reset request from a watchdog. The external pin and the low-supply flag are asynchronous, so each passes through its own synchronizer. A low pulse on the pin is honoured only if it lasts long enough, so short glitches are discarded. Every source, once it goes away, leaves the chip in reset for a fixed hold time. This hold time is a parameter. At a 4 MHz clock, 600,000 cycles gives roughly 150 ms.

The power-good input serves as the block's own synchronous active-low reset. While it is low, every internal register is forced to its start state and the output is driven high. When it goes high, the hold countdown starts. A source that appears while the hold is counting reloads the counter to its full value, so the output is released only after a full quiet hold period that follows the last source.

In the timing terms below, "edge 0" is the first rising clock edge at which an input change is sampled. "The output after edge k" is the value of `sys_rst` between edge k and edge k+1. H is `HOLD_CYCLES` and M is `MIN_LOW_CLKS`.

Top module: `chip_reset_seq`

## Requirements
- R1: While `pwr_good` is sampled low, `sys_rst` is high after every such edge.
- R2: After `pwr_good` returns high, `sys_rst` stays high through the edge H-1 counted from the first edge that samples it high, and goes low after edge H. If power-good was low at edges 0..w-1, `sys_rst` falls after edge w+H.
- R3: `lowv_det` passes through a two-stage synchronizer. A rise of `lowv_det` sampled at edge 0 makes `sys_rst` high after edge 2.
- R4: Suppose `lowv_det` was last sampled high at edge j and nothing else requests reset. Then `sys_rst` goes low after edge j+H+3 and not earlier.
- R5: Suppose `ext_rst_n` is sampled low at fewer than M consecutive edges, and nothing else requests reset. Then `sys_rst` stays low.
- R6: Suppose `ext_rst_n` is sampled low at M or more consecutive edges starting at edge 0. Then `sys_rst` becomes high after edge M+2.
- R7: Suppose a qualified low on `ext_rst_n` was last sampled low at edge N-1. Then `sys_rst` goes low after edge N+H+3.
- R8: `wdt_req` is sampled without a synchronizer. `sys_rst` is high after each edge that samples it high. If the last such edge is j, `sys_rst` goes low after edge j+H+1.
- R9: A source that arrives while the hold is counting restarts the full hold. The release time depends only on the last source, as given in R4, R7 and R8.
- R10: Low pulses on `ext_rst_n` that are each shorter than M cycles do not add up. A single high sample between two such pulses clears the low count, so `sys_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power-good level, active high; also acts as the block's synchronous active-low reset |
| lowv_det | input | 1 | Low-supply comparator output, high while the supply is too low; asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low; asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous to `clk` |
| sys_rst | output | 1 | Registered chip reset, active high |

## Verification
The hardest cases to reach are at the edge of the pin filter. One is a pin low that lasts exactly M-1 or exactly M sampled cycles. The other is two sub-threshold pulses separated by a single high sample, which must not be added together. The stimulus drives the pin for a chosen number of sampled edges, counted right after a falling clock edge. It sweeps the low length from 1 to M+3 and also runs the split-pulse pattern. Restart during the hold is reached by issuing a second watchdog or low-supply pulse at chosen offsets into a running countdown, including the very last cycle before release.

// File: rtl/rst_seq_pkg.sv
// Package: shared types for the chip reset sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package rst_seq_pkg;

    // One bit per reset source that can restart the hold countdown.
    typedef struct packed {
        logic lowv;   // synchronized low-supply flag
        logic pin;    // qualified external reset pin
        logic wdt;    // watchdog request
    } rst_cause_t;

endpackage

// File: rtl/rst_seq_sync.sv
// Module: rst_seq_sync
// Moves an asynchronous level into the clk domain through a chain of
// flip-flops. The output lags the input by STAGES sampled edges.
// Assumes STAGES >= 2 and a synchronous active-low rst_n. RESET_VAL is the
// value the chain holds during reset, which should be the input's idle level.
module rst_seq_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stg;

    // Shift the sampled input along the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RESET_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/rst_seq_pin_filter.sv
// Module: rst_seq_pin_filter
// Counts consecutive low samples of the synchronized external reset pin and
// raises 'held' once MIN_LOW of them have been seen. The count saturates, and
// any high sample clears it, so separate short pulses never add up.
// Assumes pin_n_s is already synchronous to clk and MIN_LOW >= 1.
module rst_seq_pin_filter #(
    parameter int MIN_LOW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_s,
    output logic held
);

    localparam int              CW    = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0]   MIN_V = CW'(MIN_LOW);

    logic [CW-1:0] lowcnt;

    // Count the current low run, saturating at the qualification length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lowcnt <= '0;
        end else if (pin_n_s) begin
            lowcnt <= '0;
        end else if (lowcnt != MIN_V) begin
            lowcnt <= lowcnt + 1'b1;
        end
    end

    assign held = (lowcnt == MIN_V);

    AST_FILTER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        lowcnt <= MIN_V);                                   // R5
    AST_FILTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pin_n_s |=> !held);                                 // R10

endmodule

// File: rtl/rst_seq_hold.sv
// Module: rst_seq_hold
// Keeps the chip reset high while any source is present, then for HOLD
// further cycles. A source seen during the countdown reloads it to full.
// Leaving reset counts as a source that ended one cycle earlier: the counter
// starts full and the output starts high.
// Assumes HOLD >= 1.
module rst_seq_hold
    import rst_seq_pkg::*;
#(
    parameter int HOLD = 600000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rst_cause_t cause,
    output logic       sys_rst
);

    localparam int            CW     = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt;
    logic          any_cause;

    assign any_cause = |cause;

    // Reload on any source, otherwise count down to zero; register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= HOLD_V;
            sys_rst <= 1'b1;
        end else begin
            if (any_cause) begin
                cnt <= HOLD_V;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            sys_rst <= any_cause || (cnt != '0);
        end
    end

    AST_CAUSE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        any_cause |=> sys_rst);                             // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= HOLD_V);                                     // R2
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> ($past(cnt) == '0));             // R9

endmodule

// File: rtl/chip_reset_seq.sv
// Module: chip_reset_seq (top)
// Combines power-good, low-supply, external pin and watchdog reset sources
// into one registered active-high chip reset, with a common hold time.
// Assumes pwr_good is already synchronous to clk (it is used as the
// synchronous active-low reset of every register here). lowv_det and
// ext_rst_n are asynchronous. wdt_req comes from a clk-domain watchdog.
module chip_reset_seq
    import rst_seq_pkg::*;
#(
    parameter int HOLD_CYCLES  = 600000,
    parameter int MIN_LOW_CLKS = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic lowv_det,
    input  logic ext_rst_n,
    input  logic wdt_req,
    output logic sys_rst
);

    logic       rst_n;
    logic       lowv_s;
    logic       pin_n_s;
    logic       pin_held;
    rst_cause_t cause;

    assign rst_n = pwr_good;

    // Bring the low-supply flag into the clock domain.
    rst_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_lowv_sync (
        .clk(clk), .rst_n(rst_n), .d(lowv_det), .q(lowv_s));

    // Bring the external reset pin into the clock domain.
    rst_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(pin_n_s));

    // Qualify the pin by its minimum low time.
    rst_seq_pin_filter #(.MIN_LOW(MIN_LOW_CLKS)) u_pin_filter (
        .clk(clk), .rst_n(rst_n), .pin_n_s(pin_n_s), .held(pin_held));

    // Gather the sources that restart the hold.
    always_comb begin
        cause.lowv = lowv_s;
        cause.pin  = pin_held;
        cause.wdt  = wdt_req;
    end

    // Stretch the reset after the last source goes away.
    rst_seq_hold #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .cause(cause), .sys_rst(sys_rst));

    AST_PWR_BAD_RST: assert property (@(posedge clk)
        !pwr_good |=> sys_rst);                             // R1
    AST_LOWV_HELD: assert property (@(posedge clk) disable iff (!pwr_good)
        lowv_s |=> sys_rst);                                // R3

endmodule

// File: tb/chip_reset_seq_tb.sv
// Bench for chip_reset_seq with a small hold and filter length. Expected
// edge indices come from the timing arithmetic in the requirements.
module chip_reset_seq_tb;

    localparam int H   = 20;
    localparam int M   = 4;
    localparam int WIN = 70;

    localparam int SRC_PWR  = 0;
    localparam int SRC_LOWV = 1;
    localparam int SRC_PIN  = 2;
    localparam int SRC_WDT  = 3;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic lowv_det = 1'b0;
    logic ext_rst_n = 1'b1;
    logic wdt_req = 1'b0;
    logic sys_rst;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chip_reset_seq #(.HOLD_CYCLES(H), .MIN_LOW_CLKS(M), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .pwr_good(pwr_good), .lowv_det(lowv_det),
        .ext_rst_n(ext_rst_n), .wdt_req(wdt_req), .sys_rst(sys_rst));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_src(input int src, input bit active);
        case (src)
            SRC_PWR:  pwr_good  = !active;
            SRC_LOWV: lowv_det  = active;
            SRC_PIN:  ext_rst_n = !active;
            default:  wdt_req   = active;
        endcase
    endtask

    // Assert a source for 'width' edges from edge 0, and again for 'width'
    // edges from edge 'gap' when gap > 0. Record the first edge after which
    // sys_rst is high and the first later edge after which it is low.
    task automatic measure(input int src, input int width, input int gap,
                           output int first_hi, output int fall_idx);
        first_hi = -1;
        fall_idx = -1;
        for (int k = 0; k < WIN; k++) begin
            set_src(src, (k < width) || (gap > 0 && k >= gap && k < gap + width));
            @(negedge clk);
            if (sys_rst && first_hi < 0) first_hi = k;
            if (!sys_rst && first_hi >= 0 && fall_idx < 0) fall_idx = k;
        end
        set_src(src, 1'b0);
    endtask

    initial begin
        int fh;
        int fi;
        int hi_cnt;
        // R1: reset state while power is bad
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(sys_rst === 1'b1, "R1", int'(sys_rst), 1);
        end
        // R2: release from power-on
        pwr_good = 1'b1;
        hi_cnt = 0;
        for (int k = 0; k < H + 5; k++) begin
            @(negedge clk);
            if (sys_rst) hi_cnt++;
        end
        chk(hi_cnt == H, "R2", hi_cnt, H);
        chk(sys_rst === 1'b0, "R2", int'(sys_rst), 0);

        // R5 / R6 / R7: sweep the pin low length
        for (int n = 1; n <= M + 3; n++) begin
            measure(SRC_PIN, n, 0, fh, fi);
            if (n < M) begin
                chk(fh == -1, "R5", fh, -1);
            end else begin
                chk(fh == M + 2, "R6", fh, M + 2);
                chk(fi == n + H + 3, "R7", fi, n + H + 3);
            end
        end
        // R10: two short pulses split by one high sample
        measure(SRC_PIN, M - 1, M, fh, fi);
        chk(fh == -1, "R10", fh, -1);

        // R8: watchdog pulses of several widths
        for (int w = 1; w <= 3; w++) begin
            measure(SRC_WDT, w, 0, fh, fi);
            chk(fh == 0, "R8", fh, 0);
            chk(fi == w + H, "R8", fi, w + H);
        end
        // R9: a second watchdog pulse restarts the hold, up to its last cycle
        for (int g = 3; g <= H; g += 17 - 10) begin
            measure(SRC_WDT, 1, g, fh, fi);
            chk(fi == g + 1 + H, "R9", fi, g + 1 + H);
        end
        measure(SRC_WDT, 1, H, fh, fi);
        chk(fi == 2 * H + 1, "R9", fi, 2 * H + 1);

        // R3 / R4: low-supply flag of several widths
        for (int w = 1; w <= 3; w++) begin
            measure(SRC_LOWV, w, 0, fh, fi);
            chk(fh == 2, "R3", fh, 2);
            chk(fi == w + H + 2, "R4", fi, w + H + 2);
        end
        // R9: a low-supply pulse during the hold restarts it
        measure(SRC_LOWV, 1, 8, fh, fi);
        chk(fi == 8 + 1 + H + 2, "R9", fi, 11 + H);

        // R1 / R2: power dips of several widths
        for (int w = 1; w <= 3; w++) begin
            measure(SRC_PWR, w, 0, fh, fi);
            chk(fh == 0, "R1", fh, 0);
            chk(fi == w + H, "R2", fi, w + H);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule